// File: doc/BRIEF.md
# Nibble-Pair Colour Index Assembler

This block turns a stream of 4-bit pixel codes into 8-bit colour indices for a 256-colour display path. Each valid pixel code selects one of sixteen entries in a writable attribute table. Only the low four bits of the entry are used. That 4-bit result is shifted into a running 8-bit index, and the other half of the index is kept from the previous pixel. A direction input picks the assembly order. In left assembly the new nibble enters at the bottom. In right assembly it enters at the top.

Only every second assembled value is a true colour. The values in between hold half of each neighbouring value. A phase input chooses whether the first, third, fifth and later indices of a line are captured, or the second, fourth and later ones. The captured index appears on a latched output together with a one-cycle strobe.

The running index carries across memory-word boundaries. It is cleared only by the line-start pulse, which also restarts the phase count.

Top module: `nibble_pair_assembler`

## Requirements
- R1: After reset, `run_idx` and `lat_idx` are 00h, `lat_valid` is 0 and every table entry is 0.
- R2: A table write stores only `tbl_data[3:0]`, and the bits above them have no effect on any later index.
- R3: With `dir_right`=0, a valid pixel gives a new `run_idx` equal to the previous index shifted left by four, with the table result in bits 3-0. With an identity table, a previous index of FEh and pixels 0..7, the indices are E0h, 01h, 12h, 23h, 34h, 45h, 56h, 67h.
- R4: With `dir_right`=1, a valid pixel gives a new `run_idx` equal to the previous index shifted right by four, with the table result in bits 7-4. With an identity table, a previous index of FEh and pixels 1,0,3,2,5,4,7,6, the indices are 1Fh, 01h, 30h, 23h, 52h, 45h, 74h, 67h.
- R5: `run_idx` changes on the clock edge after a valid pixel, and holds while `pix_valid` and `line_start` are both low.
- R6: `line_start` clears the running index. A pixel presented in the same cycle is assembled against 00h. Without a pixel, `run_idx` reads 00h on the next cycle.
- R7: The pixel presented with `line_start` is index 0 of the line, and each later valid pixel adds one. With `latch_odd`=0 the even-numbered indices are captured; with `latch_odd`=1 the odd-numbered ones are. On the edge after a captured pixel, `lat_idx` equals `run_idx` and `lat_valid` is 1 for that cycle only. Otherwise `lat_idx` holds its value.
- R8: A table write updates one entry per clock. A pixel presented in the same cycle as a write to its entry uses the old entry, and a pixel presented in a later cycle uses the new one.
- R9: Between line starts the running index is never cleared, so the held half carries from one group of pixels into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Start of a scan line: clears the running index and the phase |
| pix_valid | input | 1 | `pix` carries a pixel this cycle |
| pix | input | 4 | Pixel code, the table address |
| dir_right | input | 1 | 0 selects left assembly, 1 selects right assembly |
| latch_odd | input | 1 | 0 captures even-numbered indices, 1 captures odd-numbered ones |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 4 | Table entry to write |
| tbl_data | input | 8 | Entry value; only bits 3-0 are kept |
| run_idx | output | 8 | Running assembled index |
| lat_idx | output | 8 | Last captured index |
| lat_valid | output | 1 | One-cycle strobe when `lat_idx` is updated |

## Verification
Both worked sequences are checked value by value. A design that shifts the wrong way, or drops the held nibble, breaks them at once. Sweeps over every direction and phase setting mix in gaps in `pix_valid`, mid-stream line starts and table writes that land in the same cycle as lookups of the same entry. These would expose a design that reads the new entry too early, that clears the index at a gap, or that does not restart the phase at a line start and so captures mixed values. Writes with non-zero upper bits show up as wrong indices if those bits leak into the output.

// File: rtl/nibble_pair_assembler.sv
module nibble_pair_assembler #(
  parameter int NIB_W   = 4,
  parameter int ENTRY_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_start,
  input  logic                 pix_valid,
  input  logic [NIB_W-1:0]     pix,
  input  logic                 dir_right,
  input  logic                 latch_odd,
  input  logic                 tbl_we,
  input  logic [NIB_W-1:0]     tbl_addr,
  input  logic [ENTRY_W-1:0]   tbl_data,
  output logic [2*NIB_W-1:0]   run_idx,
  output logic [2*NIB_W-1:0]   lat_idx,
  output logic                 lat_valid
);
  localparam int IDX_W   = 2 * NIB_W;
  localparam int ENTRIES = 1 << NIB_W;

  logic [NIB_W-1:0] tbl_q [ENTRIES];
  logic [IDX_W-1:0] run_q, lat_q, base, nxt;
  logic [NIB_W-1:0] look;
  logic             phase_q, phase_now, take, lv_q;
  logic             unused_hi;

  assign unused_hi = ^tbl_data[ENTRY_W-1:NIB_W];

  assign look      = tbl_q[pix];
  assign base      = line_start ? '0 : run_q;
  assign nxt       = dir_right ? {look, base[IDX_W-1:NIB_W]} : {base[NIB_W-1:0], look};
  assign phase_now = line_start ? 1'b0 : phase_q;
  assign take      = pix_valid && (phase_now == latch_odd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
    end else if (tbl_we) begin
      tbl_q[tbl_addr] <= tbl_data[NIB_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= '0;
      lat_q   <= '0;
      lv_q    <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      if (pix_valid)       run_q <= nxt;
      else if (line_start) run_q <= '0;
      if (pix_valid)       phase_q <= ~phase_now;
      else if (line_start) phase_q <= 1'b0;
      lv_q <= take;
      if (take) lat_q <= nxt;
    end
  end

  assign run_idx   = run_q;
  assign lat_idx   = lat_q;
  assign lat_valid = lv_q;
endmodule

module nibble_pair_assembler_chk #(
  parameter int NIB_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               line_start,
  input logic               pix_valid,
  input logic               dir_right,
  input logic [2*NIB_W-1:0] run_idx,
  input logic [2*NIB_W-1:0] lat_idx,
  input logic               lat_valid
);
  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid && !line_start) |=> $stable(run_idx));

  a_r6_clear_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !pix_valid) |=> (run_idx == '0));

  a_r3_left_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !line_start && !dir_right) |=> (run_idx[2*NIB_W-1:NIB_W] == $past(run_idx[NIB_W-1:0])));

  a_r4_right_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !line_start && dir_right) |=> (run_idx[NIB_W-1:0] == $past(run_idx[2*NIB_W-1:NIB_W])));

  a_r7_latch_matches: assert property (@(posedge clk) disable iff (!rst_n)
    lat_valid |-> (lat_idx == run_idx));

  a_r7_latch_needs_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !lat_valid);

  a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> $stable(lat_idx));
endmodule

bind nibble_pair_assembler nibble_pair_assembler_chk #(.NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .pix_valid(pix_valid),
  .dir_right(dir_right), .run_idx(run_idx), .lat_idx(lat_idx), .lat_valid(lat_valid)
);

// File: tb/nibble_pair_assembler_test.sv
`timescale 1ns/1ps
module nibble_pair_assembler_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic line_start = 0, pix_valid = 0, dir_right = 0, latch_odd = 0, tbl_we = 0;
  logic [3:0] pix = 0, tbl_addr = 0;
  logic [7:0] tbl_data = 0;
  logic [7:0] run_idx, lat_idx;
  logic lat_valid;

  int checks = 0, failures = 0;
  logic [3:0] tbl_m [16];
  logic [7:0] run_m = 0, lat_m = 0;
  logic ph_m = 0, lv_m = 0;

  always #10 clk = ~clk;

  nibble_pair_assembler uut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .pix_valid(pix_valid), .pix(pix),
    .dir_right(dir_right), .latch_odd(latch_odd), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_data(tbl_data), .run_idx(run_idx), .lat_idx(lat_idx), .lat_valid(lat_valid)
  );

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic ls, input logic pv, input logic [3:0] p, input logic dr,
                      input logic lo, input logic we, input logic [3:0] wa,
                      input logic [7:0] wd, input string tag);
    logic [3:0] look;
    logic [7:0] base, nx;
    logic phn;
    @(negedge clk);
    line_start = ls; pix_valid = pv; pix = p; dir_right = dr; latch_odd = lo;
    tbl_we = we; tbl_addr = wa; tbl_data = wd;
    look = tbl_m[p];
    base = ls ? 8'h00 : run_m;
    nx   = dr ? {look, base[7:4]} : {base[3:0], look};
    phn  = ls ? 1'b0 : ph_m;
    lv_m = 1'b0;
    if (pv) begin
      run_m = nx;
      if (phn == lo) begin lat_m = nx; lv_m = 1'b1; end
      ph_m = ~phn;
    end else if (ls) begin
      run_m = 8'h00;
      ph_m = 1'b0;
    end
    if (we) tbl_m[wa] = wd[3:0];
    @(posedge clk); #2;
    chk(run_idx == run_m, tag, run_idx, run_m);
    chk(lat_valid == lv_m, "R7 strobe", {7'd0, lat_valid}, {7'd0, lv_m});
    chk(lat_idx == lat_m, "R7 latched", lat_idx, lat_m);
  endtask

  initial begin
    #(20ns * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] exp_l [8];
    logic [7:0] exp_r [8];
    logic [3:0] ord_r [8];
    exp_l = '{8'hE0, 8'h01, 8'h12, 8'h23, 8'h34, 8'h45, 8'h56, 8'h67};
    exp_r = '{8'h1F, 8'h01, 8'h30, 8'h23, 8'h52, 8'h45, 8'h74, 8'h67};
    ord_r = '{4'h1, 4'h0, 4'h3, 4'h2, 4'h5, 4'h4, 4'h7, 4'h6};
    for (int i = 0; i < 16; i++) tbl_m[i] = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    chk(run_idx == 8'h00, "R1 run", run_idx, 8'h00);
    chk(lat_idx == 8'h00, "R1 lat", lat_idx, 8'h00);
    chk(lat_valid == 1'b0, "R1 strobe", {7'd0, lat_valid}, 8'h00);

    // R1: table cleared, so any pixel yields 0 nibbles
    step(1, 1, 4'h9, 0, 0, 0, 0, 0, "R1 table");
    step(0, 1, 4'hC, 0, 0, 0, 0, 0, "R1 table");

    // R2: identity table loaded with junk in the upper bits
    for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, 1, 4'(i), {4'(15 - i) | 4'h8, 4'(i)}, "R5");
    step(1, 1, 4'h5, 0, 0, 0, 0, 0, "R2");
    chk(run_idx == 8'h05, "R2 upper bits", run_idx, 8'h05);

    // R3 worked sequence, odd phase keeps true values
    step(1, 1, 4'hF, 0, 1, 0, 0, 0, "R6");
    step(0, 1, 4'hE, 0, 1, 0, 0, 0, "R3");
    for (int i = 0; i < 8; i++) begin
      step(0, 1, 4'(i), 0, 1, 0, 0, 0, "R3");
      chk(run_idx == exp_l[i], "R3 sequence", run_idx, exp_l[i]);
    end
    chk(lat_idx == 8'h67, "R9 carry latched", lat_idx, 8'h67);

    // R4 worked sequence
    step(1, 1, 4'hE, 1, 1, 0, 0, 0, "R6");
    step(0, 1, 4'hF, 1, 1, 0, 0, 0, "R4");
    for (int i = 0; i < 8; i++) begin
      step(0, 1, ord_r[i], 1, 1, 0, 0, 0, "R4");
      chk(run_idx == exp_r[i], "R4 sequence", run_idx, exp_r[i]);
    end

    // R8: same-cycle write uses old entry, next pixel uses new
    step(1, 1, 4'h3, 0, 0, 1, 4'h3, 8'h0B, "R8 old");
    chk(run_idx == 8'h03, "R8 old entry", run_idx, 8'h03);
    step(0, 1, 4'h3, 0, 0, 0, 0, 0, "R8 new");
    chk(run_idx == 8'h3B, "R8 new entry", run_idx, 8'h3B);

    // R6: idle line start clears index
    step(0, 0, 0, 0, 0, 0, 0, 0, "R5");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R6");
    chk(run_idx == 8'h00, "R6 idle clear", run_idx, 8'h00);

    // Sweep: directions, phases, gaps, line starts, writes during lookups
    for (int dr = 0; dr < 2; dr++)
      for (int lo = 0; lo < 2; lo++)
        for (int k = 0; k < 48; k++) begin
          logic ls, pv, we;
          string tag;
          ls = (k % 17 == 0);
          pv = (k % 5 != 3);
          we = (k % 3 == 0);
          tag = ls ? "R6" : (!pv ? "R5" : (we ? "R8" : (dr != 0 ? "R4" : "R3")));
          step(ls, pv, 4'((k * 5 + dr * 3 + lo) & 15), 1'(dr), 1'(lo), we,
               4'((k * 7 + 1) & 15), {4'(k) ^ 4'h9, 4'((k * 11 + dr) & 15)}, tag);
        end

    @(negedge clk);
    pix_valid = 0; line_start = 0; tbl_we = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule